// File: doc/BRIEF.md
# Two-Lane Parallel Histogram Builder

This block builds a single histogram from a data set that arrives already split into two partitions, one per input lane. Each lane carries a stream of bin indices qualified by a valid bit, and the last sample of a partition is flagged by an end marker. A start pulse opens a task. Both lanes then feed their own counting element at the same time, each taking up to one sample per clock. Once both partitions have ended, a merge stage walks the bins in ascending order and writes the sum of the two partial counts into a result memory. After that, a done flag rises.

Each counting element keeps its partial histogram in a memory with one cycle of read latency. It holds the count of the bin it is currently visiting in a register, so a run of equal bins never waits on the memory. When the bin changes, the finished run is written back while the new bin is read. Because of this, the read and the write in one cycle never go to the same address. Counting can be split across lanes like this because addition is commutative and associative. After done, software-side logic reads the final counts through a synchronous read port.

Top module: `hist_mapreduce`

## Requirements
- R1: After reset, done is low and the block is idle, so the first start pulse opens a task.
- R2: A start pulse is accepted only while no task is mapping or merging. An accepted start clears done on the next edge. A start while busy has no effect on the counts or on when done rises.
- R3: During mapping, a lane counts one sample on each clock edge where its valid is high. Cycles with valid low add nothing. Samples offered before an accepted start, or after that lane's end marker, are not counted.
- R4: The end marker is qualified by valid and belongs to a counted sample. A partition of exactly one sample is therefore legal.
- R5: After done, the final count of bin k equals the number of samples equal to k in lane 0 plus the number in lane 1 for that task.
- R6: Counts are exact for every ordering, including long runs of one bin, a bin revisited two samples later (k, j, k), and alternating bins.
- R7: Each accepted start clears both partial histograms, so no count from an earlier task appears in a later result.
- R8: Each lane may deliver up to 2^CNT_W-1 samples per task. The final count is CNT_W+1 bits wide and holds the largest possible sum without wrapping.
- R9: The merge begins only once both lanes have ended. The lanes may end on different cycles and with different sample counts.
- R10: Done rises exactly 2^BIN_W+3 clock edges after the edge that samples the later of the two end markers. It then stays high until a start is accepted.
- R11: Read data for rd_addr appears after the next rising edge, which is one cycle of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Opens a task when idle |
| a_valid | input | 1 | Lane 0 sample valid |
| a_bin | input | BIN_W | Lane 0 bin index |
| a_last | input | 1 | Lane 0 end marker, qualified by a_valid |
| b_valid | input | 1 | Lane 1 sample valid |
| b_bin | input | BIN_W | Lane 1 bin index |
| b_last | input | 1 | Lane 1 end marker, qualified by b_valid |
| rd_addr | input | BIN_W | Result read address |
| rd_data | output | CNT_W+1 | Final count of the addressed bin, one cycle later |
| done | output | 1 | Result complete; held until the next accepted start |

## Verification
The hardest case to reach is a bin that is written back in one cycle and read again in the very next. This happens with the k, j, k pattern, where the count for k must come from a write that has only just landed. The bench drives it with an interleaved pattern on one lane while the other lane carries runs of four with idle cycles cut in. It also drives two full lanes of 2^CNT_W-1 samples into one bin to reach the widest sum. Start pulses during mapping and stray samples after an end marker are mixed into one task. Every result is then compared against counts computed arithmetically from the same sample formulas.

// File: rtl/hist_pkg.sv
package hist_pkg;

  // Per-lane counting element phases
  typedef enum logic [1:0] {
    PE_IDLE  = 2'd0,
    PE_RUN   = 2'd1,
    PE_FLUSH = 2'd2,
    PE_DONE  = 2'd3
  } pe_state_t;

  // Task-level phases
  typedef enum logic [1:0] {
    TOP_IDLE  = 2'd0,
    TOP_MAP   = 2'd1,
    TOP_MERGE = 2'd2
  } top_state_t;

endpackage

// File: rtl/hist_pe.sv
// One counting element: partial histogram with run merging at one sample per cycle.
module hist_pe
  import hist_pkg::*;
#(
  parameter int BIN_W = 4,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic             in_valid,
  input  logic [BIN_W-1:0] in_bin,
  input  logic             in_last,
  input  logic [BIN_W-1:0] ext_addr,
  output logic [CNT_W-1:0] part_cnt,
  output logic             pe_done
);

  localparam int NBINS = 1 << BIN_W;

  pe_state_t        state_q, state_d;
  logic [BIN_W-1:0] cur_q, cur_d;     // bin of the open run
  logic [CNT_W-1:0] run_q, run_d;     // count held outside memory
  logic             base_q, base_d;   // memory base for the run is in flight
  logic             open_q, open_d;   // a run is open
  logic [CNT_W-1:0] rdata_q;
  logic [CNT_W-1:0] run_eff;
  logic [BIN_W-1:0] rd_ptr;
  logic             wr_en;
  logic             take;
  logic             same;

  logic [CNT_W-1:0] mem [NBINS];
  logic [NBINS-1:0] vld_q;

  // Next-state logic
  always_comb begin
    run_eff = run_q + (base_q ? rdata_q : '0);
    take    = (state_q == PE_RUN) && in_valid;
    same    = open_q && (in_bin == cur_q);
    state_d = state_q;
    cur_d   = cur_q;
    run_d   = run_eff;
    base_d  = 1'b0;
    open_d  = open_q;
    wr_en   = 1'b0;
    if (go) begin
      state_d = PE_RUN;
      open_d  = 1'b0;
      run_d   = '0;
    end else begin
      case (state_q)
        PE_RUN: begin
          if (take) begin
            if (same) begin
              run_d = run_eff + CNT_W'(1);
            end else begin
              wr_en  = open_q;
              run_d  = CNT_W'(1);
              base_d = 1'b1;
              cur_d  = in_bin;
              open_d = 1'b1;
            end
            if (in_last) state_d = PE_FLUSH;
          end
        end
        PE_FLUSH: begin
          wr_en   = 1'b1;
          state_d = PE_DONE;
        end
        default: ;
      endcase
    end
  end

  assign rd_ptr   = (state_q == PE_RUN) ? in_bin : ext_addr;
  assign part_cnt = rdata_q;
  assign pe_done  = (state_q == PE_DONE);

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PE_IDLE;
      cur_q   <= '0;
      run_q   <= '0;
      base_q  <= 1'b0;
      open_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cur_q   <= cur_d;
      run_q   <= run_d;
      base_q  <= base_d;
      open_q  <= open_d;
    end
  end

  // Bin-valid flags give a single-cycle clear of the partial histogram
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
    end else if (go) begin
      vld_q <= '0;
    end else if (wr_en) begin
      vld_q[cur_q] <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else begin
      rdata_q <= vld_q[rd_ptr] ? mem[rd_ptr] : '0;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[cur_q] <= run_eff;
  end

endmodule

// File: rtl/hist_merge.sv
// Bin-wise reduction: one bin read per cycle, summed write one cycle later.
module hist_merge #(
  parameter int BIN_W = 4,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic [CNT_W-1:0] cnt_a,
  input  logic [CNT_W-1:0] cnt_b,
  output logic [BIN_W-1:0] rd_addr,
  output logic             wr_en,
  output logic [BIN_W-1:0] wr_addr,
  output logic [CNT_W:0]   wr_data,
  output logic             last_wr
);

  localparam logic [BIN_W-1:0] LAST_BIN = {BIN_W{1'b1}};

  logic             act_q, act_d;
  logic [BIN_W-1:0] idx_q, idx_d;
  logic             wv_q;
  logic [BIN_W-1:0] wa_q;

  always_comb begin
    act_d = act_q;
    idx_d = idx_q;
    if (go) begin
      act_d = 1'b1;
      idx_d = '0;
    end else if (act_q) begin
      idx_d = idx_q + BIN_W'(1);
      if (idx_q == LAST_BIN) act_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      idx_q <= '0;
      wv_q  <= 1'b0;
      wa_q  <= '0;
    end else begin
      act_q <= act_d;
      idx_q <= idx_d;
      wv_q  <= act_q;
      wa_q  <= idx_q;
    end
  end

  assign rd_addr = idx_q;
  assign wr_en   = wv_q;
  assign wr_addr = wa_q;
  assign wr_data = {1'b0, cnt_a} + {1'b0, cnt_b};
  assign last_wr = wv_q && (wa_q == LAST_BIN);

endmodule

// File: rtl/hist_store.sv
// Final histogram memory with a registered read port.
module hist_store #(
  parameter int BIN_W = 4,
  parameter int DAT_W = 9
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [BIN_W-1:0] wr_addr,
  input  logic [DAT_W-1:0] wr_data,
  input  logic [BIN_W-1:0] rd_addr,
  output logic [DAT_W-1:0] rd_data
);

  localparam int NBINS = 1 << BIN_W;

  logic [DAT_W-1:0] mem [NBINS];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
    rd_data <= mem[rd_addr];
  end

endmodule

// File: rtl/hist_mapreduce.sv
module hist_mapreduce
  import hist_pkg::*;
#(
  parameter int BIN_W = 4,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             a_valid,
  input  logic [BIN_W-1:0] a_bin,
  input  logic             a_last,
  input  logic             b_valid,
  input  logic [BIN_W-1:0] b_bin,
  input  logic             b_last,
  input  logic [BIN_W-1:0] rd_addr,
  output logic [CNT_W:0]   rd_data,
  output logic             done
);

  localparam int LANES = 2;
  localparam int OUT_W = CNT_W + 1;

  // Reset: asynchronous assert, synchronous release
  logic [1:0] rsync_q;
  logic       rst_sn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_sn = rsync_q[1];

  // Lane fan-in
  logic [LANES-1:0] lane_valid;
  logic [LANES-1:0] lane_last;
  logic [LANES-1:0] lane_done;
  logic [BIN_W-1:0] lane_bin [LANES];
  logic [CNT_W-1:0] lane_cnt [LANES];

  assign lane_valid  = {b_valid, a_valid};
  assign lane_last   = {b_last, a_last};
  assign lane_bin[0] = a_bin;
  assign lane_bin[1] = b_bin;

  top_state_t       state_q, state_d;
  logic             done_q, done_d;
  logic             go_map;
  logic             go_merge;
  logic [BIN_W-1:0] mg_rd_addr;
  logic             mg_wr_en;
  logic [BIN_W-1:0] mg_wr_addr;
  logic [OUT_W-1:0] mg_wr_data;
  logic             mg_last;

  // Task control
  always_comb begin
    go_map   = start && (state_q == TOP_IDLE);
    go_merge = (state_q == TOP_MAP) && (&lane_done);
    state_d  = state_q;
    done_d   = done_q;
    case (state_q)
      TOP_IDLE:  if (go_map) state_d = TOP_MAP;
      TOP_MAP:   if (go_merge) state_d = TOP_MERGE;
      TOP_MERGE: if (mg_last) state_d = TOP_IDLE;
      default:   state_d = TOP_IDLE;
    endcase
    if (go_map)       done_d = 1'b0;
    else if (mg_last) done_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      state_q <= TOP_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
    end
  end

  assign done = done_q;

  // Map stage: one counting element per lane
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    hist_pe #(
      .BIN_W (BIN_W),
      .CNT_W (CNT_W)
    ) u_pe (
      .clk      (clk),
      .rst_n    (rst_sn),
      .go       (go_map),
      .in_valid (lane_valid[g]),
      .in_bin   (lane_bin[g]),
      .in_last  (lane_last[g]),
      .ext_addr (mg_rd_addr),
      .part_cnt (lane_cnt[g]),
      .pe_done  (lane_done[g])
    );
  end

  // Reduce stage
  hist_merge #(
    .BIN_W (BIN_W),
    .CNT_W (CNT_W)
  ) u_merge (
    .clk     (clk),
    .rst_n   (rst_sn),
    .go      (go_merge),
    .cnt_a   (lane_cnt[0]),
    .cnt_b   (lane_cnt[1]),
    .rd_addr (mg_rd_addr),
    .wr_en   (mg_wr_en),
    .wr_addr (mg_wr_addr),
    .wr_data (mg_wr_data),
    .last_wr (mg_last)
  );

  hist_store #(
    .BIN_W (BIN_W),
    .DAT_W (OUT_W)
  ) u_store (
    .clk     (clk),
    .wr_en   (mg_wr_en),
    .wr_addr (mg_wr_addr),
    .wr_data (mg_wr_data),
    .rd_addr (rd_addr),
    .rd_data (rd_data)
  );

endmodule

// File: rtl/hist_mapreduce_chk.sv
module hist_mapreduce_chk #(
  parameter int BIN_W = 4
) (
  input logic             clk,
  input logic             rst_sn,
  input logic             start,
  input logic             done,
  input logic [1:0]       lane_done,
  input logic             mg_wr_en,
  input logic [BIN_W-1:0] mg_wr_addr
);

  AST_START_CLEARS_DONE: assert property (@(posedge clk) disable iff (!rst_sn)
    start && done |=> !done); // R2

  AST_DONE_HELD: assert property (@(posedge clk) disable iff (!rst_sn)
    done && !start |=> done); // R10

  AST_MERGE_AFTER_MAP: assert property (@(posedge clk) disable iff (!rst_sn)
    mg_wr_en |-> (&lane_done)); // R9

  AST_BIN_ORDER: assert property (@(posedge clk) disable iff (!rst_sn)
    mg_wr_en && $past(mg_wr_en) |-> mg_wr_addr == $past(mg_wr_addr) + BIN_W'(1)); // R5

  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_sn)
    $rose(done) |-> $past(mg_wr_en) && ($past(mg_wr_addr) == {BIN_W{1'b1}})); // R10

endmodule

bind hist_mapreduce hist_mapreduce_chk #(
  .BIN_W (BIN_W)
) u_chk (
  .clk        (clk),
  .rst_sn     (rst_sn),
  .start      (start),
  .done       (done),
  .lane_done  (lane_done),
  .mg_wr_en   (mg_wr_en),
  .mg_wr_addr (mg_wr_addr)
);

// File: tb/tb_hist_mapreduce.sv
module tb_hist_mapreduce;

  localparam int BIN_W = 4;
  localparam int CNT_W = 8;
  localparam int NBINS = 1 << BIN_W;

  logic             clk;
  logic             rst_n;
  logic             start;
  logic             a_valid, b_valid;
  logic [BIN_W-1:0] a_bin, b_bin;
  logic             a_last, b_last;
  logic [BIN_W-1:0] rd_addr;
  logic [CNT_W:0]   rd_data;
  logic             done;

  hist_mapreduce #(.BIN_W(BIN_W), .CNT_W(CNT_W)) dut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .a_valid(a_valid), .a_bin(a_bin), .a_last(a_last),
    .b_valid(b_valid), .b_bin(b_bin), .b_last(b_last),
    .rd_addr(rd_addr), .rd_data(rd_data), .done(done)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0;
  int n_fail = 0;
  int exp_cnt [NBINS];

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic int bin_of(input int kind, input int lane, input int i);
    case (kind)
      0: return (lane == 0) ? (i % 16) : (15 - (i % 16));
      1: return (lane == 0) ? (((i % 4) == 0 || (i % 4) == 2) ? 6 : ((i * 7) % 16))
                            : ((i / 4) % 16);
      2: return (lane == 0) ? ((i * i) % 16) : 1;
      3: return 9;
      4: return (lane == 0) ? (i % 2) : ((i / 5) % 3);
      default: return (lane == 0) ? 0 : 15;
    endcase
  endfunction

  task automatic run_task(input int kind, input int la, input int lb, input bit gaps,
                          input bit stray, input bit poke, input string req);
    int ia = 0;
    int ib = 0;
    int t = 0;
    int end_a = 0;
    int end_b = 0;
    int w = 0;
    int lat;
    for (int k = 0; k < NBINS; k++) exp_cnt[k] = 0;
    for (int i = 0; i < la; i++) exp_cnt[bin_of(kind, 0, i)]++;
    for (int i = 0; i < lb; i++) exp_cnt[bin_of(kind, 1, i)]++;

    if (stray) begin
      // R3: samples offered while idle must not count
      @(negedge clk);
      a_valid = 1'b1; a_bin = 4'd3; a_last = 1'b1;
      b_valid = 1'b1; b_bin = 4'd3; b_last = 1'b0;
      repeat (3) @(negedge clk);
      a_valid = 1'b0; b_valid = 1'b0;
    end

    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;

    while (ia < la || ib < lb) begin
      bit sa;
      bit sb;
      sa = (ia < la);
      sb = (ib < lb) && !(gaps && (t % 3 == 2));
      a_valid = sa || (stray && ia >= la);
      a_bin   = sa ? BIN_W'(bin_of(kind, 0, ia)) : 4'd2;
      a_last  = sa ? (ia == la - 1) : 1'b1;
      b_valid = sb || (stray && ib >= lb);
      b_bin   = sb ? BIN_W'(bin_of(kind, 1, ib)) : 4'd2;
      b_last  = sb ? (ib == lb - 1) : 1'b1;
      start   = poke && (t == 4);  // R2: start while mapping
      @(negedge clk);
      if (sa) begin
        if (ia == la - 1) end_a = cyc;
        ia++;
      end
      if (sb) begin
        if (ib == lb - 1) end_b = cyc;
        ib++;
      end
      t++;
    end
    start = 1'b0;
    if (!stray) begin
      a_valid = 1'b0; b_valid = 1'b0;
    end
    while (!done && w < 2000) begin
      @(negedge clk);
      w++;
    end
    a_valid = 1'b0; b_valid = 1'b0;
    a_last = 1'b0; b_last = 1'b0;

    lat = cyc - ((end_a > end_b) ? end_a : end_b);
    chk(done && (lat == NBINS + 3), {req, " R10 done latency"}, lat, NBINS + 3);

    for (int k = 0; k < NBINS; k++) begin
      rd_addr = BIN_W'(k);
      @(negedge clk);
      chk(int'(rd_data) == exp_cnt[k], {req, " R11 R5 bin ", $sformatf("%0d", k)},
          int'(rd_data), exp_cnt[k]);
    end
    chk(done == 1'b1, {req, " R10 done held"}, int'(done), 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    start = 1'b0;
    a_valid = 1'b0; a_bin = '0; a_last = 1'b0;
    b_valid = 1'b0; b_bin = '0; b_last = 1'b0;
    rd_addr = '0;
    #23 rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(done == 1'b0, "R1 done after reset", int'(done), 0);

    run_task(0, 16, 16, 1'b0, 1'b0, 1'b0, "R5");
    run_task(1, 64, 50, 1'b1, 1'b0, 1'b0, "R6 R3 gaps");
    run_task(2, 40, 5, 1'b0, 1'b0, 1'b0, "R9 uneven");
    run_task(3, 255, 255, 1'b0, 1'b0, 1'b0, "R8 widest");
    run_task(0, 16, 16, 1'b0, 1'b0, 1'b0, "R7 no leak");
    run_task(4, 20, 20, 1'b0, 1'b1, 1'b1, "R2 R3 stray");
    run_task(5, 1, 1, 1'b0, 1'b0, 1'b0, "R4 single");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule